// File: doc/BRIEF.md
# Indexed Effective Address Sequencer

This block forms the effective address of an 8-bit processor instruction, one bus cycle at a time, after the opcode byte has already been fetched. It is started with an addressing-mode code, an access class (read, store or read-modify-write), the current program counter and the two index registers. It then walks the exact bus cycle pattern of that mode. This pattern includes the dummy reads that the processor makes at partially formed addresses. When the pattern is complete, it presents the final address, the high address byte as fetched before indexing, the advanced program counter and, for read-modify-write, the operand byte.

Memory answers combinationally: the byte on `bus_rdata` must belong to the `bus_addr` driven in the same cycle. Read instructions pay the page-crossing cycle only when the low-byte sum carries. Store and read-modify-write instructions always spend that cycle. Read-modify-write adds an operand read and a write-back of the unchanged value before the block hands over to execute.

Top module: `eas_seq`

## Requirements
- R1: After reset `busy`, `bus_rd`, `bus_wr` and `ea_valid` are all low, and the bus stays quiet whenever `busy` is low.
- R2: Zero-page modes (mode 0 plain, 1 indexed by X, 2 indexed by Y) read the base byte at the program counter. The indexed variants then make a dummy read at `{0x00, base}`. The final address is `{0x00, (base + index) mod 256}` and never leaves page zero.
- R3: Modes that take an address from the instruction stream read the low byte at PC and then the high byte at PC+1 (absolute, mode 3). `pc_out` equals the start PC plus the number of instruction bytes consumed (1 for zero-page and indirect modes, 2 for absolute modes).
- R4: For read class (code 0), absolute indexed (mode 4 by X, mode 5 by Y) and post-indexed indirect with no carry out of low byte plus index go straight to completion. With a carry, one extra dummy read occurs at `{high, (low+index) mod 256}`, and 0x100 is added to that address.
- R5: For store (code 1) and read-modify-write (code 2), indexed absolute and post-indexed indirect always take the extra dummy read at the uncorrected address. 0x100 is added only when the low-byte sum carried. The high byte wraps modulo 256.
- R6: Pre-indexed indirect (mode 6) reads the pointer at PC, makes a dummy read at `{0x00, ptr}`, then reads the low byte at `{0x00, (ptr+X) mod 256}` and the high byte at `{0x00, (ptr+X+1) mod 256}`.
- R7: Post-indexed indirect (mode 7) reads the pointer at PC, the low byte at `{0x00, ptr}` and the high byte at `{0x00, (ptr+1) mod 256}`, then indexes by Y under the rules of R4 and R5.
- R8: For read-modify-write, once the address is formed, one cycle reads the operand at it and the next writes the same byte back to it. The byte is also presented on `rmw_data`.
- R9: `base_hi` holds the high address byte as read from memory before any index or page correction; it is zero for zero-page modes.
- R10: `ea_valid` is a one-cycle pulse after the last bus cycle, after which `busy` drops. `start` while busy is ignored, as are changes of `mode`, `cls`, `pc_in`, `x_in` and `y_in`.
- R11: Access class code 3 behaves exactly as read class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence; taken only when not busy |
| mode | input | 3 | Addressing-mode code (R2, R3, R4, R6, R7) |
| cls | input | 2 | Access class: 0 read, 1 store, 2 read-modify-write, 3 read |
| pc_in | input | 2*DATA_W | Program counter pointing at the first operand byte |
| x_in | input | DATA_W | X index register |
| y_in | input | DATA_W | Y index register |
| bus_rdata | input | DATA_W | Read data for the current `bus_addr` |
| busy | output | 1 | Sequence in progress |
| bus_addr | output | 2*DATA_W | Bus address of the current cycle |
| bus_rd | output | 1 | Current cycle is a read (including dummy reads) |
| bus_wr | output | 1 | Current cycle is a write |
| bus_wdata | output | DATA_W | Write data |
| ea_valid | output | 1 | Effective address ready, one-cycle pulse |
| eff_addr | output | 2*DATA_W | Effective address |
| base_hi | output | DATA_W | Unindexed high address byte |
| pc_out | output | 2*DATA_W | Program counter after operand bytes |
| rmw_data | output | DATA_W | Operand byte read for read-modify-write |

## Verification
The bench builds the block at its default width of 8 data bits with the carry-by-compare variant of the index adder switched on. This exercises the generate branch that derives the page carry from a comparison against the inverted index instead of the ninth sum bit. The 8-bit width puts exact page boundaries within reach: a low byte plus index of exactly 0xFF and exactly 0x100, a zero-page pointer at 0xFF that wraps to 0x00, and a high byte of 0xFF that wraps on page correction. Every bus cycle of every mode and class is compared against a behavioural model, so a misplaced or missing dummy read shows up as an address mismatch in that very cycle.

// File: rtl/eas_pkg.sv
`timescale 1ns/1ps
package eas_pkg;

   // addressing modes; the code values are part of the interface
   typedef enum logic [2:0] {
      AM_ZP    = 3'd0,
      AM_ZPX   = 3'd1,
      AM_ZPY   = 3'd2,
      AM_ABS   = 3'd3,
      AM_ABSX  = 3'd4,
      AM_ABSY  = 3'd5,
      AM_PREX  = 3'd6,
      AM_POSTY = 3'd7
   } am_e;

   // access classes; code 3 is treated as read
   typedef enum logic [1:0] {
      AC_READ  = 2'd0,
      AC_STORE = 2'd1,
      AC_RMW   = 2'd2,
      AC_RSVD  = 2'd3
   } ac_e;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_LO   = 4'd1,   // operand byte 1 at PC
      ST_HI   = 4'd2,   // operand byte 2 at PC
      ST_ZIDX = 4'd3,   // zero-page dummy read before index add
      ST_PDUM = 4'd4,   // pointer dummy read before X add
      ST_PLO  = 4'd5,   // pointer low byte
      ST_PHI  = 4'd6,   // pointer high byte
      ST_FIX  = 4'd7,   // dummy read at uncorrected address
      ST_MRD  = 4'd8,   // operand read
      ST_MWR  = 4'd9,   // unchanged write-back
      ST_DONE = 4'd10   // effective address presented
   } st_e;

   function automatic logic is_read_class(input ac_e c);
      return (c == AC_READ) || (c == AC_RSVD);
   endfunction

   function automatic logic uses_y(input am_e m);
      return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_POSTY);
   endfunction

endpackage

// File: rtl/eas_idx_add.sv
`timescale 1ns/1ps
module eas_idx_add #(
   parameter int W                = 8,
   parameter bit CARRY_BY_COMPARE = 1'b0
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] idx,
   output logic [W-1:0] sum,
   output logic         carry
);

   initial begin
      assert (W >= 2) else $fatal(1, "eas_idx_add: W must be at least 2");
   end

   generate
      if (CARRY_BY_COMPARE) begin : g_cmp
         // carry out iff base exceeds the headroom left above idx
         assign sum   = base + idx;
         assign carry = (base > ~idx);
      end else begin : g_wide
         logic [W:0] wide;
         assign wide  = {1'b0, base} + {1'b0, idx};
         assign sum   = wide[W-1:0];
         assign carry = wide[W];
      end
   endgenerate

endmodule

// File: rtl/eas_ctrl.sv
`timescale 1ns/1ps
module eas_ctrl
   import eas_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  am_e  mode_q,
   input  ac_e  cls_q,
   input  logic carry,
   output st_e  state
);

   st_e nxt;
   st_e settle;
   st_e after_idx;

   // once the address is final: either operand read or hand-over
   assign settle    = (cls_q == AC_RMW) ? ST_MRD : ST_DONE;
   // reads skip the fix cycle when no carry; others always pay it
   assign after_idx = (is_read_class(cls_q) && !carry) ? settle : ST_FIX;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: if (start) nxt = ST_LO;
         ST_LO: begin
            case (mode_q)
               AM_ZP:                    nxt = settle;
               AM_ZPX, AM_ZPY:           nxt = ST_ZIDX;
               AM_ABS, AM_ABSX, AM_ABSY: nxt = ST_HI;
               AM_PREX:                  nxt = ST_PDUM;
               default:                  nxt = ST_PLO;
            endcase
         end
         ST_HI:   nxt = (mode_q == AM_ABS) ? settle : after_idx;
         ST_ZIDX: nxt = settle;
         ST_PDUM: nxt = ST_PLO;
         ST_PLO:  nxt = ST_PHI;
         ST_PHI:  nxt = (mode_q == AM_POSTY) ? after_idx : settle;
         ST_FIX:  nxt = settle;
         ST_MRD:  nxt = ST_MWR;
         ST_MWR:  nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R10
   restart_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state != ST_LO));

   // R8
   wb_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MRD) |=> (state == ST_MWR));

endmodule

// File: rtl/eas_seq.sv
`timescale 1ns/1ps
module eas_seq
   import eas_pkg::*;
#(
   parameter int DATA_W           = 8,
   parameter bit CARRY_BY_COMPARE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [2:0]            mode,
   input  logic [1:0]            cls,
   input  logic [2*DATA_W-1:0]   pc_in,
   input  logic [DATA_W-1:0]     x_in,
   input  logic [DATA_W-1:0]     y_in,
   input  logic [DATA_W-1:0]     bus_rdata,
   output logic                  busy,
   output logic [2*DATA_W-1:0]   bus_addr,
   output logic                  bus_rd,
   output logic                  bus_wr,
   output logic [DATA_W-1:0]     bus_wdata,
   output logic                  ea_valid,
   output logic [2*DATA_W-1:0]   eff_addr,
   output logic [DATA_W-1:0]     base_hi,
   output logic [2*DATA_W-1:0]   pc_out,
   output logic [DATA_W-1:0]     rmw_data
);

   localparam int ADDR_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] PAGE0 = '0;

   initial begin
      assert (DATA_W >= 4 && DATA_W <= 16)
         else $fatal(1, "eas_seq: DATA_W out of supported range");
   end

   st_e                state;
   am_e                mode_q;
   ac_e                cls_q;
   logic [DATA_W-1:0]  x_q, y_q;
   logic [ADDR_W-1:0]  pc_q;
   logic [DATA_W-1:0]  lo_q;      // address low byte or pointer
   logic [DATA_W-1:0]  ptr_q;     // zero-page pointer
   logic [ADDR_W-1:0]  ea_q;
   logic [DATA_W-1:0]  bh_q;
   logic               cross_q;
   logic [DATA_W-1:0]  opnd_q;

   logic               accept;
   logic [DATA_W-1:0]  idx;
   logic [DATA_W-1:0]  sum;
   logic               carry;

   assign accept = start && (state == ST_IDLE);
   assign idx    = uses_y(mode_q) ? y_q : x_q;

   eas_idx_add #(
      .W                (DATA_W),
      .CARRY_BY_COMPARE (CARRY_BY_COMPARE)
   ) u_add (
      .base  (lo_q),
      .idx   (idx),
      .sum   (sum),
      .carry (carry)
   );

   eas_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .mode_q (mode_q),
      .cls_q  (cls_q),
      .carry  (carry),
      .state  (state)
   );

   // datapath registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= AM_ZP;
         cls_q   <= AC_READ;
         x_q     <= '0;
         y_q     <= '0;
         pc_q    <= '0;
         lo_q    <= '0;
         ptr_q   <= '0;
         ea_q    <= '0;
         bh_q    <= '0;
         cross_q <= 1'b0;
         opnd_q  <= '0;
      end else begin
         if (accept) begin
            mode_q <= am_e'(mode);
            cls_q  <= ac_e'(cls);
            x_q    <= x_in;
            y_q    <= y_in;
            pc_q   <= pc_in;
         end
         case (state)
            ST_LO: begin
               pc_q    <= pc_q + 1'b1;
               lo_q    <= bus_rdata;
               ptr_q   <= bus_rdata;
               bh_q    <= '0;
               ea_q    <= {PAGE0, bus_rdata};
               cross_q <= 1'b0;
            end
            ST_HI: begin
               pc_q    <= pc_q + 1'b1;
               bh_q    <= bus_rdata;
               ea_q    <= {bus_rdata, (mode_q == AM_ABS) ? lo_q : sum};
               cross_q <= (mode_q != AM_ABS) && carry;
            end
            ST_ZIDX: ea_q  <= {PAGE0, sum};
            ST_PDUM: ptr_q <= sum;
            ST_PLO:  lo_q  <= bus_rdata;
            ST_PHI: begin
               bh_q    <= bus_rdata;
               ea_q    <= {bus_rdata, (mode_q == AM_POSTY) ? sum : lo_q};
               cross_q <= (mode_q == AM_POSTY) && carry;
            end
            ST_FIX: begin
               if (cross_q) ea_q[ADDR_W-1:DATA_W] <= ea_q[ADDR_W-1:DATA_W] + 1'b1;
            end
            ST_MRD:  opnd_q <= bus_rdata;
            default: ;
         endcase
      end
   end

   // bus address per cycle
   always_comb begin
      bus_addr = '0;
      bus_rd   = 1'b0;
      bus_wr   = 1'b0;
      case (state)
         ST_LO, ST_HI: begin
            bus_addr = pc_q;
            bus_rd   = 1'b1;
         end
         ST_ZIDX: begin
            bus_addr = {PAGE0, lo_q};
            bus_rd   = 1'b1;
         end
         ST_PDUM, ST_PLO: begin
            bus_addr = {PAGE0, ptr_q};
            bus_rd   = 1'b1;
         end
         ST_PHI: begin
            bus_addr = {PAGE0, ptr_q + 1'b1};
            bus_rd   = 1'b1;
         end
         ST_FIX, ST_MRD: begin
            bus_addr = ea_q;
            bus_rd   = 1'b1;
         end
         ST_MWR: begin
            bus_addr = ea_q;
            bus_wr   = 1'b1;
         end
         default: ;
      endcase
   end

   assign bus_wdata = opnd_q;
   assign busy      = (state != ST_IDLE);
   assign ea_valid  = (state == ST_DONE);
   assign eff_addr  = ea_q;
   assign base_hi   = bh_q;
   assign pc_out    = pc_q;
   assign rmw_data  = opnd_q;

   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_rd && !bus_wr && !ea_valid));

   // R8
   wb_same_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> ($past(bus_rd) && bus_addr == $past(bus_addr)
                  && bus_wdata == $past(bus_rdata)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |=> (!ea_valid && !busy));

   // R2
   zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
         |-> (eff_addr[ADDR_W-1:DATA_W] == '0));

endmodule

// File: tb/eas_seq_tb.sv
`timescale 1ns/1ps
module eas_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  cls = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  x_in = '0, y_in = '0;
   logic [7:0]  bus_rdata;
   logic        busy, bus_rd, bus_wr, ea_valid;
   logic [15:0] bus_addr, eff_addr, pc_out;
   logic [7:0]  bus_wdata, base_hi, rmw_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] mem [int];
   int q_kind[$];
   int q_addr[$];
   int q_data[$];

   always #2.5 clk = ~clk;

   eas_seq #(.DATA_W(8), .CARRY_BY_COMPARE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cls(cls),
      .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .bus_rdata(bus_rdata),
      .busy(busy), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .ea_valid(ea_valid), .eff_addr(eff_addr),
      .base_hi(base_hi), .pc_out(pc_out), .rmw_data(rmw_data)
   );

   function automatic int rdm(input int a);
      if (mem.exists(a)) return int'(mem[a]);
      return ((a * 37 + 11) ^ (a >> 8)) & 255;
   endfunction

   always_comb bus_rdata = bus_rd ? 8'(rdm(int'(bus_addr))) : 8'h00;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input int k, input int a, input int d);
      q_kind.push_back(k);
      q_addr.push_back(a & 16'hFFFF);
      q_data.push_back(d);
   endtask

   // indexed step shared by absolute indexed and post-indexed modes
   task automatic idx_step(input int hi, input int lo, input int ix, input bit rdc,
                           output int ea);
      int s, unc;
      s   = lo + ix;
      unc = hi * 256 + (s % 256);
      if (!(rdc && s < 256)) push(0, unc, 0);
      ea  = (s >= 256) ? ((unc + 256) % 65536) : unc;
   endtask

   task automatic run(input string req, input int md, input int cl, input int pc,
                      input int xv, input int yv, input bit poke);
      int b0, b1, l, h, p, ea, bh, pcv, v, n;
      bit rdc;
      q_kind.delete(); q_addr.delete(); q_data.delete();
      rdc = (cl == 0) || (cl == 3);
      v   = 0;
      pcv = pc;
      b0  = rdm(pcv); push(0, pcv, 0); pcv++;
      ea = 0; bh = 0;
      case (md)
         0: ea = b0;
         1, 2: begin
            push(0, b0, 0);
            ea = (b0 + ((md == 1) ? xv : yv)) % 256;
         end
         3, 4, 5: begin
            b1 = rdm(pcv); push(0, pcv, 0); pcv++;
            bh = b1;
            if (md == 3) ea = b1 * 256 + b0;
            else idx_step(b1, b0, (md == 4) ? xv : yv, rdc, ea);
         end
         6: begin
            push(0, b0, 0);
            p = (b0 + xv) % 256;
            l = rdm(p);           push(0, p, 0);
            h = rdm((p + 1) % 256); push(0, (p + 1) % 256, 0);
            bh = h; ea = h * 256 + l;
         end
         default: begin
            l = rdm(b0);            push(0, b0, 0);
            h = rdm((b0 + 1) % 256); push(0, (b0 + 1) % 256, 0);
            bh = h;
            idx_step(h, l, yv, rdc, ea);
         end
      endcase
      if (cl == 2) begin
         v = rdm(ea);
         push(0, ea, 0);
         push(1, ea, v);
      end

      @(negedge clk);
      start = 1'b1; mode = 3'(md); cls = 2'(cl);
      pc_in = 16'(pc); x_in = 8'(xv); y_in = 8'(yv);
      @(negedge clk);
      start = 1'b0;
      n = q_kind.size();
      for (int i = 0; i < n; i++) begin
         chk(req, "bus cycle kind", {bus_wr, bus_rd}, (q_kind[i] == 1) ? 2 : 1);
         chk(req, "bus address", int'(bus_addr), q_addr[i]);
         if (q_kind[i] == 1) chk("R8", "write-back data", int'(bus_wdata), q_data[i]);
         chk(req, "ea_valid early", int'(ea_valid), 0);
         if (poke && i == 0) begin
            // R10: a new start and changed inputs while busy
            start = 1'b1; mode = 3'd0; cls = 2'd2;
            pc_in = 16'hFFF0; x_in = 8'h55; y_in = 8'h66;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(req, "ea_valid", int'(ea_valid), 1);
      chk(req, "eff_addr", int'(eff_addr), ea);
      chk("R9", "base_hi", int'(base_hi), bh);
      chk("R3", "pc_out", int'(pc_out), pcv & 16'hFFFF);
      if (cl == 2) chk("R8", "rmw_data", int'(rmw_data), v);
      @(negedge clk);
      chk("R10", "busy after done", int'(busy), 0);
      chk("R1", "bus quiet after done", int'(bus_rd | bus_wr | ea_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "bus_rd in reset", int'(bus_rd), 0);
      chk("R1", "bus_wr in reset", int'(bus_wr), 0);
      chk("R1", "ea_valid in reset", int'(ea_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", int'(busy | bus_rd | bus_wr), 0);

      // R3 R11 plain zero page
      mem[16'h1234] = 8'h80;
      run("R3", 0, 0, 16'h1234, 0, 0, 1'b0);
      // R2 zero page X, wrap inside page zero
      mem[16'h0300] = 8'hC0;
      run("R2", 1, 0, 16'h0300, 8'h90, 0, 1'b0);
      // R2 zero page Y store
      mem[16'h0400] = 8'h10;
      run("R2", 2, 1, 16'h0400, 0, 8'h05, 1'b0);
      // R3 absolute read
      mem[16'h2000] = 8'h34; mem[16'h2001] = 8'h12;
      run("R3", 3, 0, 16'h2000, 0, 0, 1'b0);
      // R4 abs X read, no carry then carry
      mem[16'h2100] = 8'h10; mem[16'h2101] = 8'h12;
      run("R4", 4, 0, 16'h2100, 8'h20, 0, 1'b0);
      mem[16'h2200] = 8'hF0; mem[16'h2201] = 8'h12;
      run("R4", 4, 0, 16'h2200, 8'h20, 0, 1'b0);
      // R4 boundary: sum 0xFF (no carry) and 0x100 (carry)
      mem[16'h2300] = 8'hDF; mem[16'h2301] = 8'h40;
      run("R4", 5, 0, 16'h2300, 0, 8'h20, 1'b0);
      mem[16'h2400] = 8'hE0; mem[16'h2401] = 8'h40;
      run("R4", 5, 0, 16'h2400, 0, 8'h20, 1'b0);
      // R5 store always pays the extra cycle
      mem[16'h2500] = 8'h01; mem[16'h2501] = 8'h30;
      run("R5", 5, 1, 16'h2500, 0, 8'h02, 1'b0);
      // R5 R8 read-modify-write with carry and high byte wrap
      mem[16'h2600] = 8'hFF; mem[16'h2601] = 8'hFF;
      run("R5", 4, 2, 16'h2600, 8'h03, 0, 1'b0);
      // R6 pre-indexed with pointer wrap
      mem[16'h2700] = 8'hF0; mem[16'h00FF] = 8'h34; mem[16'h0000] = 8'h56;
      run("R6", 6, 0, 16'h2700, 8'h0F, 0, 1'b0);
      // R7 post-indexed read, pointer wrap and page carry
      mem[16'h2800] = 8'hFF; mem[16'h00FF] = 8'hF8; mem[16'h0000] = 8'h40;
      run("R7", 7, 0, 16'h2800, 0, 8'h10, 1'b0);
      // R7 post-indexed store, no carry
      mem[16'h2900] = 8'h20; mem[16'h0020] = 8'h05; mem[16'h0021] = 8'h50;
      run("R7", 7, 1, 16'h2900, 0, 8'h01, 1'b0);
      // R7 post-indexed read, no carry
      run("R7", 7, 0, 16'h2900, 0, 8'h01, 1'b0);
      // R8 zero-page and pre-indexed read-modify-write
      mem[16'h2A00] = 8'h44; mem[16'h0044] = 8'hA5;
      run("R8", 0, 2, 16'h2A00, 0, 0, 1'b0);
      mem[16'h2B00] = 8'h10; mem[16'h0012] = 8'h00; mem[16'h0013] = 8'h60;
      run("R8", 6, 2, 16'h2B00, 8'h02, 0, 1'b0);
      // R10 start and input changes while busy are ignored
      run("R10", 4, 0, 16'h2200, 8'h20, 0, 1'b1);
      // R11 class 3 skips the extra cycle like a read
      run("R11", 4, 3, 16'h2100, 8'h20, 0, 1'b0);
      // R11 class 3 with carry takes it like a read
      run("R11", 4, 3, 16'h2200, 8'h20, 0, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule